// File: doc/BRIEF.md
# Linked-List Descriptor Fetcher

This block serves one DMA channel. It follows a chain of descriptors kept in memory and loads each one into the channel's shadow registers. A start pulse supplies three things: the pointer to the first descriptor, the bus interface to read it from, and its layout code. The block then reads the descriptor one word at a time over a simple request/valid read port, and only one read is in flight at any time. Each returned word goes into the shadow register for its slot: next pointer, microblock control, source address, destination address, configuration, block control, data stride, source microblock stride and destination microblock stride.

The layout code is 2 bits and sets how many words a descriptor has and in what order they arrive. The microblock control word of each descriptor carries three flags. One decides whether the source address is taken. One decides whether the destination address is taken. The third decides whether another descriptor follows, and two more bits give that next descriptor's layout. A one-cycle descriptor-ready pulse marks each loaded descriptor. The end of the chain is marked by a one-cycle chain-done pulse. A disable request lets the descriptor being read finish, and the block then stops.

The controller has five states:
- **IDLE**: waits for start.
- **ISSUE**: drives one read request.
- **WAIT**: waits for the read data.
- **NOTIFY**: pulses descriptor-ready.
- **DONE**: pulses chain-done.

The transitions are:
- IDLE→ISSUE on start.
- ISSUE→WAIT always.
- WAIT→ISSUE on a returned word that is not the descriptor's last.
- WAIT→NOTIFY on the last word.
- NOTIFY→DONE when the next-enable flag is 0.
- NOTIFY→IDLE when a disable is pending and the next-enable flag is 1.
- NOTIFY→ISSUE otherwise.
- DONE→IDLE always.

Top module: `desc_chain_walker`

## Requirements
- R1: While reset is asserted and after it is released, busy, rd_req, desc_ready and chain_done are 0 and every shadow register is 0.
- R2: A start pulse is accepted only when the block is idle. The first read goes to start_ptr with bits 1:0 cleared, on interface start_ptr[0] (rd_if), and uses layout start_view. A start pulse while busy has no effect.
- R3: The layout code sets the words of a descriptor in read order. Code 0 is {next, uctl, dst}. Code 1 is {next, uctl, src, dst}. Code 2 is code 1 followed by cfg. Code 3 is code 2 followed by bctl, stride, src_us and dst_us, for nine words in all.
- R4: At most one read is outstanding: rd_req is a single-cycle pulse, and the next pulse comes only after rd_valid. Within a descriptor, each read address is 4 above the one before it.
- R5: In the microblock control word, bits 23:0 are the length, bit 24 is next-enable, bit 25 is source-update, bit 26 is destination-update and bits 28:27 are the layout of the next descriptor. The next descriptor is read from the next-pointer word with bits 1:0 cleared, on interface bit 0 of that word.
- R6: When source-update is 0, the source word is read but sh_src keeps its previous value. Destination-update controls sh_dst in the same way. All other slots load unconditionally.
- R7: desc_ready is high for exactly the one cycle after the last word of a descriptor is accepted, and the shadow registers hold that descriptor's values in that cycle. If the chain continues, the next read request is issued in the following cycle.
- R8: If next-enable is 0, chain_done is high in the cycle after desc_ready and busy is 0 in the cycle after that. No further reads are issued. This holds even when a disable request arrives at the same time.
- R9: A disable request received while busy lets the current descriptor complete. If that descriptor has next-enable 1, busy is 0 in the cycle after desc_ready, no chain_done is given and no further reads are issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start pulse, honoured only when idle |
| start_ptr | input | W | First descriptor pointer; bit 0 selects the interface |
| start_view | input | 2 | Layout code of the first descriptor |
| disable_req | input | 1 | Request to stop after the current descriptor |
| rd_req | output | 1 | Single-cycle read request |
| rd_addr | output | W | Word-aligned read address |
| rd_if | output | 1 | Bus interface select for the read |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | W | Read data |
| busy | output | 1 | Block is walking a chain |
| desc_ready | output | 1 | Pulse: a descriptor has been loaded |
| chain_done | output | 1 | Pulse: the chain has ended |
| sh_next | output | W | Shadow: next-descriptor pointer |
| sh_uctl | output | W | Shadow: microblock control |
| sh_src | output | W | Shadow: source address |
| sh_dst | output | W | Shadow: destination address |
| sh_cfg | output | W | Shadow: configuration |
| sh_bctl | output | W | Shadow: block control |
| sh_stride | output | W | Shadow: data stride |
| sh_src_us | output | W | Shadow: source microblock stride |
| sh_dst_us | output | W | Shadow: destination microblock stride |

## Verification
The two functions that can meet in one cycle are the disable capture and the end-of-descriptor decision. The bench provokes this by raising disable_req in the same cycle that the last word of a descriptor returns. It does so once on a descriptor whose next-enable is 0, where chain_done must still follow desc_ready. It does so once on a descriptor whose next-enable is 1, where busy must drop in the cycle after desc_ready with no chain_done and no further read. A scoreboard holds the expected read addresses and the shadow contents for each descriptor, and flags any extra or missing read.

// File: rtl/dcw_pkg.sv
package dcw_pkg;

    localparam int unsigned NUM_SLOTS   = 9;
    localparam int unsigned IDX_W       = $clog2(NUM_SLOTS);
    localparam int unsigned LEN_W       = 24;
    localparam int unsigned BIT_NEXT_EN = LEN_W;
    localparam int unsigned BIT_SRC_UPD = LEN_W + 1;
    localparam int unsigned BIT_DST_UPD = LEN_W + 2;
    localparam int unsigned BIT_VIEW_LO = LEN_W + 3;

    typedef logic [1:0] view_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_NOTIFY,
        ST_DONE
    } fetch_state_e;

    // Shadow slot numbering; order matches the fully populated layout
    typedef enum logic [IDX_W-1:0] {
        SL_NEXT   = 4'd0,
        SL_UCTL   = 4'd1,
        SL_SRC    = 4'd2,
        SL_DST    = 4'd3,
        SL_CFG    = 4'd4,
        SL_BCTL   = 4'd5,
        SL_STRIDE = 4'd6,
        SL_SUS    = 4'd7,
        SL_DUS    = 4'd8
    } slot_e;

    // Index of the final word for a layout code
    function automatic logic [IDX_W-1:0] last_index(input view_t v);
        logic [IDX_W-1:0] r;
        case (v)
            2'd0:    r = IDX_W'(2);
            2'd1:    r = IDX_W'(3);
            2'd2:    r = IDX_W'(4);
            default: r = IDX_W'(NUM_SLOTS - 1);
        endcase
        return r;
    endfunction

    // Slot targeted by word k of a descriptor with layout v
    function automatic logic [IDX_W-1:0] slot_of(input view_t v, input logic [IDX_W-1:0] k);
        logic [IDX_W-1:0] r;
        if (v == 2'd0 && k == IDX_W'(2))
            r = SL_DST;
        else
            r = k;
        return r;
    endfunction

endpackage

// File: rtl/dcw_seq.sv
module dcw_seq
    import dcw_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [W-1:0]     start_ptr_i,
    input  logic [1:0]       start_view_i,
    input  logic             disable_i,
    input  logic             rd_valid_i,
    input  logic             next_en_i,
    input  logic [W-1:0]     next_ptr_i,
    input  logic [1:0]       next_view_i,
    output logic             rd_req_o,
    output logic [W-1:0]     rd_addr_o,
    output logic             rd_if_o,
    output logic             busy_o,
    output logic             desc_ready_o,
    output logic             chain_done_o,
    output logic             load_en_o,
    output logic [IDX_W-1:0] load_slot_o
);

    localparam logic [W-1:0] WORD_STEP = W'(4);

    fetch_state_e     state_q, state_d;
    logic [W-1:0]     addr_q;
    logic             if_q;
    view_t            view_q;
    logic [IDX_W-1:0] word_q;
    logic             stop_q;
    logic             last_word;
    logic             halt;

    assign last_word = (word_q == last_index(view_q));
    assign halt      = stop_q | disable_i;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_ISSUE;
            ST_ISSUE:  state_d = ST_WAIT;
            ST_WAIT:   if (rd_valid_i) state_d = last_word ? ST_NOTIFY : ST_ISSUE;
            ST_NOTIFY: begin
                if (!next_en_i)
                    state_d = ST_DONE;
                else if (halt)
                    state_d = ST_IDLE;
                else
                    state_d = ST_ISSUE;
            end
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Fetch pointer, word counter, layout and pending stop
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            if_q   <= 1'b0;
            view_q <= '0;
            word_q <= '0;
            stop_q <= 1'b0;
        end else if (state_q == ST_IDLE) begin
            if (start_i) begin
                addr_q <= {start_ptr_i[W-1:2], 2'b00};
                if_q   <= start_ptr_i[0];
                view_q <= start_view_i;
                word_q <= '0;
                stop_q <= 1'b0;
            end
        end else begin
            if (disable_i)
                stop_q <= 1'b1;
            if (state_q == ST_WAIT && rd_valid_i && !last_word) begin
                addr_q <= addr_q + WORD_STEP;
                word_q <= word_q + IDX_W'(1);
            end
            if (state_q == ST_NOTIFY && next_en_i && !halt) begin
                addr_q <= {next_ptr_i[W-1:2], 2'b00};
                if_q   <= next_ptr_i[0];
                view_q <= next_view_i;
                word_q <= '0;
            end
        end
    end

    // Outputs
    always_comb begin
        rd_req_o     = (state_q == ST_ISSUE);
        busy_o       = (state_q != ST_IDLE);
        desc_ready_o = (state_q == ST_NOTIFY);
        chain_done_o = (state_q == ST_DONE);
        load_en_o    = (state_q == ST_WAIT) && rd_valid_i;
        load_slot_o  = slot_of(view_q, word_q);
        rd_addr_o    = addr_q;
        rd_if_o      = if_q;
    end

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |=> !rd_req_o); // R4

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && rd_valid_i && !last_word) |=> (rd_addr_o == $past(rd_addr_o) + WORD_STEP)); // R4

    AST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |-> (rd_addr_o[1:0] == 2'b00)); // R2

    AST_DONE_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
        chain_done_o |-> $past(desc_ready_o)); // R8

    AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_ready_o && halt && next_en_i) |=> (!busy_o && !rd_req_o)); // R9

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && start_i && !rd_valid_i) |=> (state_q == ST_WAIT)); // R2

endmodule

// File: rtl/dcw_shadow.sv
module dcw_shadow
    import dcw_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en_i,
    input  logic [IDX_W-1:0] load_slot_i,
    input  logic [W-1:0]     data_i,
    output logic [W-1:0]     regs_o [NUM_SLOTS],
    output logic             next_en_o,
    output logic [1:0]       next_view_o
);

    logic [W-1:0] uctl;

    assign uctl        = regs_o[SL_UCTL];
    assign next_en_o   = uctl[BIT_NEXT_EN];
    assign next_view_o = uctl[BIT_VIEW_LO +: 2];

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        logic         gate;
        logic         hit;
        logic [W-1:0] q;

        if (g == int'(SL_SRC)) begin : g_src
            assign gate = uctl[BIT_SRC_UPD];
            AST_SRC_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
                (load_en_i && load_slot_i == IDX_W'(g) && !uctl[BIT_SRC_UPD]) |=> $stable(regs_o[g])); // R6
        end else if (g == int'(SL_DST)) begin : g_dst
            assign gate = uctl[BIT_DST_UPD];
            AST_DST_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
                (load_en_i && load_slot_i == IDX_W'(g) && !uctl[BIT_DST_UPD]) |=> $stable(regs_o[g])); // R6
        end else begin : g_plain
            assign gate = 1'b1;
        end

        assign hit = load_en_i && (load_slot_i == IDX_W'(g)) && gate;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q <= '0;
            else if (hit)
                q <= data_i;
        end

        assign regs_o[g] = q;
    end

endmodule

// File: rtl/desc_chain_walker.sv
module desc_chain_walker
    import dcw_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] start_ptr,
    input  logic [1:0]   start_view,
    input  logic         disable_req,
    output logic         rd_req,
    output logic [W-1:0] rd_addr,
    output logic         rd_if,
    input  logic         rd_valid,
    input  logic [W-1:0] rd_data,
    output logic         busy,
    output logic         desc_ready,
    output logic         chain_done,
    output logic [W-1:0] sh_next,
    output logic [W-1:0] sh_uctl,
    output logic [W-1:0] sh_src,
    output logic [W-1:0] sh_dst,
    output logic [W-1:0] sh_cfg,
    output logic [W-1:0] sh_bctl,
    output logic [W-1:0] sh_stride,
    output logic [W-1:0] sh_src_us,
    output logic [W-1:0] sh_dst_us
);

    logic             load_en;
    logic [IDX_W-1:0] load_slot;
    logic [W-1:0]     regs [NUM_SLOTS];
    logic             next_en;
    logic [1:0]       next_view;

    dcw_seq #(.W(W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .start_ptr_i  (start_ptr),
        .start_view_i (start_view),
        .disable_i    (disable_req),
        .rd_valid_i   (rd_valid),
        .next_en_i    (next_en),
        .next_ptr_i   (regs[SL_NEXT]),
        .next_view_i  (next_view),
        .rd_req_o     (rd_req),
        .rd_addr_o    (rd_addr),
        .rd_if_o      (rd_if),
        .busy_o       (busy),
        .desc_ready_o (desc_ready),
        .chain_done_o (chain_done),
        .load_en_o    (load_en),
        .load_slot_o  (load_slot)
    );

    dcw_shadow #(.W(W)) u_shadow (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_en_i   (load_en),
        .load_slot_i (load_slot),
        .data_i      (rd_data),
        .regs_o      (regs),
        .next_en_o   (next_en),
        .next_view_o (next_view)
    );

    assign sh_next   = regs[SL_NEXT];
    assign sh_uctl   = regs[SL_UCTL];
    assign sh_src    = regs[SL_SRC];
    assign sh_dst    = regs[SL_DST];
    assign sh_cfg    = regs[SL_CFG];
    assign sh_bctl   = regs[SL_BCTL];
    assign sh_stride = regs[SL_STRIDE];
    assign sh_src_us = regs[SL_SUS];
    assign sh_dst_us = regs[SL_DUS];

    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        desc_ready |=> !desc_ready); // R7

endmodule

// File: tb/test_desc_chain_walker.sv
module test_desc_chain_walker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] start_ptr = '0;
    logic [1:0]  start_view = '0;
    logic        disable_req = 1'b0;
    logic        rd_req, rd_if, busy, desc_ready, chain_done;
    logic [31:0] rd_addr;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic [31:0] sh_next, sh_uctl, sh_src, sh_dst, sh_cfg, sh_bctl, sh_stride, sh_src_us, sh_dst_us;

    always #2 clk = ~clk;

    desc_chain_walker #(.W(32)) i_desc_chain_walker (
        .clk(clk), .rst_n(rst_n), .start(start), .start_ptr(start_ptr), .start_view(start_view),
        .disable_req(disable_req), .rd_req(rd_req), .rd_addr(rd_addr), .rd_if(rd_if),
        .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy), .desc_ready(desc_ready),
        .chain_done(chain_done), .sh_next(sh_next), .sh_uctl(sh_uctl), .sh_src(sh_src),
        .sh_dst(sh_dst), .sh_cfg(sh_cfg), .sh_bctl(sh_bctl), .sh_stride(sh_stride),
        .sh_src_us(sh_src_us), .sh_dst_us(sh_dst_us)
    );

    int total = 0;
    int bad = 0;

    task automatic check(input bit ok, input string tag, input logic [287:0] act, input logic [287:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // Two memories, one per interface
    logic [31:0] mem0 [256];
    logic [31:0] mem1 [256];
    int          lat = 1;
    logic        pend;
    int          cnt;
    logic [31:0] p_a;
    logic        p_if;

    always @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
            pend     <= 1'b0;
            cnt      <= 0;
            p_a      <= '0;
            p_if     <= 1'b0;
        end else begin
            rd_valid <= 1'b0;
            if (pend) begin
                if (cnt == 0) begin
                    rd_valid <= 1'b1;
                    rd_data  <= p_if ? mem1[p_a[9:2]] : mem0[p_a[9:2]];
                    pend     <= 1'b0;
                end else begin
                    cnt <= cnt - 1;
                end
            end
            if (rd_req) begin
                pend <= 1'b1;
                cnt  <= lat - 1;
                p_a  <= rd_addr;
                p_if <= rd_if;
            end
        end
    end

    function automatic logic [31:0] rd(input logic ifc, input logic [31:0] a);
        return ifc ? mem1[a[9:2]] : mem0[a[9:2]];
    endfunction

    task automatic put(input logic ifc, input logic [31:0] a, input logic [31:0] d);
        if (ifc) mem1[a[9:2]] = d;
        else     mem0[a[9:2]] = d;
    endtask

    // R5 field positions: 23:0 len, 24 next, 25 src-upd, 26 dst-upd, 28:27 next layout
    function automatic logic [31:0] uctl(input int len, input bit nxt, input bit su, input bit du, input logic [1:0] nv);
        return {3'b000, nv, du, su, nxt, 24'(len)};
    endfunction

    // R3 word orders
    task automatic write_desc(input logic ifc, input logic [31:0] a, input logic [1:0] v,
                              input logic [31:0] nda, input logic [31:0] uc, input logic [31:0] sa,
                              input logic [31:0] da, input logic [31:0] cfg, input logic [31:0] bc,
                              input logic [31:0] ds, input logic [31:0] sus, input logic [31:0] dus);
        put(ifc, a, nda);
        put(ifc, a + 4, uc);
        if (v == 2'd0) begin
            put(ifc, a + 8, da);
        end else begin
            put(ifc, a + 8, sa);
            put(ifc, a + 12, da);
            if (v >= 2'd2) put(ifc, a + 16, cfg);
            if (v == 2'd3) begin
                put(ifc, a + 20, bc);
                put(ifc, a + 24, ds);
                put(ifc, a + 28, sus);
                put(ifc, a + 32, dus);
            end
        end
    endtask

    // Scoreboard
    logic [32:0]  exp_addr [$];
    logic [287:0] exp_desc [$];
    int           exp_after [$];
    int           exp_done = 0;
    logic [31:0]  m_sh [9];

    task automatic plan_chain(input logic [31:0] ptr, input logic [1:0] v0, input int max_desc);
        logic        ifc;
        logic [31:0] a, w0, w1;
        logic [1:0]  v;
        int          n;
        ifc = ptr[0];
        a   = {ptr[31:2], 2'b00};
        v   = v0;
        for (int d = 0; d < max_desc; d++) begin
            n = (v == 2'd0) ? 3 : (v == 2'd1) ? 4 : (v == 2'd2) ? 5 : 9;
            for (int k = 0; k < n; k++) exp_addr.push_back({ifc, a + 32'(4 * k)});
            w0 = rd(ifc, a);
            w1 = rd(ifc, a + 4);
            m_sh[0] = w0;
            m_sh[1] = w1;
            if (v == 2'd0) begin
                if (w1[26]) m_sh[3] = rd(ifc, a + 8);
            end else begin
                if (w1[25]) m_sh[2] = rd(ifc, a + 8);
                if (w1[26]) m_sh[3] = rd(ifc, a + 12);
            end
            if (v >= 2'd2) m_sh[4] = rd(ifc, a + 16);
            if (v == 2'd3) for (int j = 5; j < 9; j++) m_sh[j] = rd(ifc, a + 32'(4 * j));
            exp_desc.push_back({m_sh[8], m_sh[7], m_sh[6], m_sh[5], m_sh[4], m_sh[3], m_sh[2], m_sh[1], m_sh[0]});
            if (!w1[24]) begin
                exp_after.push_back(1);
                exp_done++;
                break;
            end
            if (d == max_desc - 1) begin
                exp_after.push_back(2);
                break;
            end
            exp_after.push_back(0);
            ifc = w0[0];
            a   = {w0[31:2], 2'b00};
            v   = w1[28:27];
        end
    endtask

    // Monitor
    int          after_code = -1;
    bit          done_seen = 1'b0;
    logic [32:0] ea;
    logic [287:0] ed;

    always @(negedge clk) begin
        if (rst_n) begin
            if (after_code >= 0) begin
                case (after_code)
                    0: check(busy && rd_req && !chain_done, "R7 continue after ready", {busy, rd_req, chain_done}, 3'b110);
                    1: check(busy && chain_done, "R8 chain_done after ready", {busy, chain_done}, 2'b11);
                    default: check(!busy && !chain_done && !rd_req, "R9 stop after ready", {busy, chain_done, rd_req}, 3'b000);
                endcase
                after_code = -1;
            end
            if (done_seen) begin
                check(!busy && !rd_req, "R8 idle after chain_done", {busy, rd_req}, 2'b00);
                done_seen = 1'b0;
            end
            if (rd_req) begin
                if (exp_addr.size() == 0) begin
                    check(1'b0, "R4 unexpected read", {rd_if, rd_addr}, 0);
                end else begin
                    ea = exp_addr.pop_front();
                    check({rd_if, rd_addr} == ea, "R3 R5 read address", {rd_if, rd_addr}, ea);
                end
            end
            if (desc_ready) begin
                if (exp_desc.size() == 0) begin
                    check(1'b0, "R7 unexpected desc_ready", 1, 0);
                end else begin
                    ed = exp_desc.pop_front();
                    check({sh_dst_us, sh_src_us, sh_stride, sh_bctl, sh_cfg, sh_dst, sh_src, sh_uctl, sh_next} == ed,
                          "R6 shadow contents",
                          {sh_dst_us, sh_src_us, sh_stride, sh_bctl, sh_cfg, sh_dst, sh_src, sh_uctl, sh_next}, ed);
                    after_code = exp_after.pop_front();
                end
            end
            if (chain_done) begin
                check(exp_done > 0, "R8 chain_done expected", 1, exp_done);
                exp_done--;
                done_seen = 1'b1;
            end
        end
    end

    task automatic launch(input logic [31:0] ptr, input logic [1:0] v);
        @(negedge clk);
        start_ptr  = ptr;
        start_view = v;
        start      = 1'b1;
        @(negedge clk);
        start      = 1'b0;
    endtask

    task automatic wait_idle(input string tag);
        int n = 0;
        while (busy && n < 5000) begin
            @(negedge clk);
            n++;
        end
        repeat (3) @(negedge clk);
        check(exp_addr.size() == 0 && exp_desc.size() == 0 && exp_done == 0, tag,
              {exp_addr.size(), exp_desc.size(), exp_done}, 0);
    endtask

    task automatic disable_on_valid(input int nth);
        int c = 0;
        while (c < nth) begin
            @(negedge clk);
            if (rd_valid) c++;
        end
        disable_req = 1'b1;
        @(negedge clk);
        disable_req = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        bad++;
        total++;
        $display("FAIL R8 watchdog act=busy exp=idle");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem0[i] = 32'(i) ^ 32'h5A00_0000;
            mem1[i] = 32'(i) ^ 32'hA500_0000;
        end
        for (int j = 0; j < 9; j++) m_sh[j] = '0;

        // S1 single layout-0 descriptor
        write_desc(1'b0, 32'h040, 2'd0, 32'h0000_0300, uctl(8, 0, 1, 1, 2'd0), 0, 32'h1111_2222, 0, 0, 0, 0, 0);
        // S2 chain A(if0,L1) -> B(if1,L2) -> C(if0,L3) -> D(if1,L0, end)
        write_desc(1'b0, 32'h100, 2'd1, 32'h0000_0201, uctl(16, 1, 1, 0, 2'd2), 32'hA5A5_0001, 32'hBAD0_0001, 0, 0, 0, 0, 0);
        write_desc(1'b1, 32'h200, 2'd2, 32'h0000_0080, uctl(32, 1, 0, 1, 2'd3), 32'hBAD0_0002, 32'hD000_0002, 32'hC0F6_0002, 0, 0, 0, 0);
        write_desc(1'b0, 32'h080, 2'd3, 32'h0000_0301, uctl(4, 1, 1, 1, 2'd0), 32'h5000_0003, 32'hD000_0003,
                   32'hC0F6_0003, 32'hB000_0003, 32'h0D50_0003, 32'h5050_0003, 32'hD0D0_0003);
        write_desc(1'b1, 32'h300, 2'd0, 32'h0000_03FC, uctl(1, 0, 0, 1, 2'd1), 0, 32'hD000_0004, 0, 0, 0, 0, 0);

        repeat (2) @(negedge clk);
        check(!busy && !rd_req && !desc_ready && !chain_done, "R1 outputs in reset", {busy, rd_req, desc_ready, chain_done}, 0);
        check({sh_next, sh_uctl, sh_src, sh_dst, sh_cfg, sh_bctl, sh_stride, sh_src_us, sh_dst_us} == 0,
              "R1 shadows in reset", {sh_next, sh_uctl, sh_src, sh_dst, sh_cfg, sh_bctl, sh_stride, sh_src_us, sh_dst_us}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!busy && !rd_req && !desc_ready && !chain_done, "R1 outputs after reset", {busy, rd_req, desc_ready, chain_done}, 0);

        // S1
        lat = 1;
        plan_chain(32'h040, 2'd0, 100);
        launch(32'h040, 2'd0);
        wait_idle("R8 single descriptor chain drained");

        // S2 full chain with a stray start while busy
        lat = 2;
        plan_chain(32'h102, 2'd1, 100);
        launch(32'h102, 2'd1);
        check(rd_req && rd_addr == 32'h100 && rd_if == 1'b0, "R2 first read address", {rd_req, rd_if, rd_addr}, {2'b10, 32'h100});
        repeat (5) @(negedge clk);
        start_ptr = 32'h040; start_view = 2'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_idle("R2 stray start ignored, chain drained");

        // S3 disable during first descriptor
        lat = 1;
        plan_chain(32'h201, 2'd2, 1);
        launch(32'h201, 2'd2);
        @(negedge clk);
        disable_req = 1'b1;
        @(negedge clk);
        disable_req = 1'b0;
        wait_idle("R9 disable mid-descriptor");

        // S4 disable together with last word, next-enable 0
        lat = 3;
        plan_chain(32'h301, 2'd0, 1);
        launch(32'h301, 2'd0);
        disable_on_valid(3);
        wait_idle("R8 disable collides with chain end");

        // S5 disable together with last word, next-enable 1
        lat = 1;
        plan_chain(32'h080, 2'd3, 1);
        launch(32'h080, 2'd3);
        disable_on_valid(9);
        wait_idle("R9 disable collides with last word");

        // S6 restart the full chain after a stop
        lat = 3;
        plan_chain(32'h100, 2'd1, 100);
        launch(32'h100, 2'd1);
        wait_idle("R7 restart after stop");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule